// File: doc/BRIEF.md
# Gate Graph Cost Analyser

This block scores a feed-forward gate graph held in an external genotype store. Each node of the graph is one two-input logic gate or an inverter, described by a function code and two source indices. A source index below `N_IN` names a primary input. Index `N_IN + j` names node `j`. After the nodes come the output genes, one per circuit output, each naming the source that drives that output.

A pulse on `start` makes the analyser walk the store through its read port. It first finds which nodes actually drive an output. It then reports three figures for those nodes only: how many gates they are, how many transistors they cost, and the longest chain of gates from a primary input to an output. Nodes that drive no output are neutral and count for nothing.

The read port is a plain combinational memory port: `rd_data` must present the word at `rd_addr` in the same cycle. The genotype must stay unchanged while the block is busy. Every source gene of node `j` must be below `N_IN + j`.

Top module: `gate_graph_cost`

## Requirements
- R1: A node is active only if an output gene selects it, or an active node uses it as a source. Inactive nodes add nothing to any count. An inverter's second source gene is never followed.
- R2: When `done` is high, `gate_cnt` equals the number of active nodes.
- R3: Function codes are 0 AND, 1 OR, 2 NAND, 3 NOR, 4 XOR, 5 XNOR, 6 and 7 inverter. When `done` is high, `trans_cnt` is the sum over active nodes of 6 for AND/OR, 4 for NAND/NOR, 12 for XOR/XNOR and 2 for an inverter.
- R4: When `done` is high, `path_len` is the largest number of active gates on any route from a primary input to an output, with every gate weighted one. An output gene that names a primary input contributes 0.
- R5: Node `j` is read at address `j`. The word holds the function code in bits [3+2*SW-1:2*SW], the first source in bits [2*SW-1:SW] and the second source in bits [SW-1:0], where SW = $clog2(N_IN+N_NODES). Output gene `k` is read at address `N_NODES+k`, with its source in bits [SW-1:0]. In the first cycle after `start` is accepted, `rd_addr` is `N_NODES`. `N_OUT` cycles later it is `N_NODES-1`.
- R6: `done` falls on the clock edge that accepts `start`. It rises on the 2*(N_NODES+N_OUT)-th edge after that one.
- R7: `start` is accepted only while idle or while `done` is high; a pulse during a run has no effect. From `done` until the next accepted `start`, all three counts hold their values.
- R8: After reset, `done` is low and all three counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins an analysis |
| rd_addr | output | $clog2(N_NODES+N_OUT) | Genotype word address |
| rd_data | input | 3+2*SW | Genotype word at `rd_addr`, same cycle |
| done | output | 1 | High while the counts are valid |
| gate_cnt | output | $clog2(N_NODES+1) | Active gate count |
| trans_cnt | output | $clog2(12*N_NODES+1) | Transistor total |
| path_len | output | $clog2(N_NODES+1) | Longest active gate path |

## Verification
Several genotype shapes are used, and each one separates a different failure.
- Outputs wired straight to primary inputs must give all-zero counts, which exposes any node counted without being reached.
- A sixteen-deep chain that cycles through every function code checks each transistor weight and the full path depth.
- A small graph where one node is reachable only through an inverter's unused second source shows whether that source is wrongly followed.
- Random graphs, one of them hit by a stray `start` mid-run, compare all three figures and the timing of `done` against a fixed-point model on every clock.

// File: rtl/gcost_pkg.sv
package gcost_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OUTM,
    PH_REV,
    PH_FWD,
    PH_OUTD,
    PH_DONE
  } gcost_phase_e;

  // codes 6 and 7 both denote an inverter
  function automatic logic is_inv(input logic [2:0] fn);
    return fn[2] & fn[1];
  endfunction

  function automatic logic [3:0] gate_cost(input logic [2:0] fn);
    logic [3:0] c;
    case (fn)
      3'd0, 3'd1: c = 4'd6;
      3'd2, 3'd3: c = 4'd4;
      3'd4, 3'd5: c = 4'd12;
      default:    c = 4'd2;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gcost_seq.sv
module gcost_seq
  import gcost_pkg::*;
#(
  parameter int N_NODES = 16,
  parameter int N_OUT   = 4,
  parameter int AW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output gcost_phase_e  phase,
  output logic [AW-1:0] idx,
  output logic [AW-1:0] rd_addr,
  output logic          accept,
  output logic          done
);

  always_comb begin
    accept  = start && (phase == PH_IDLE || phase == PH_DONE);
    done    = (phase == PH_DONE);
    rd_addr = (phase == PH_OUTM || phase == PH_OUTD) ? (AW'(N_NODES) + idx) : idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      case (phase)
        PH_IDLE, PH_DONE: begin
          if (start) begin
            phase <= PH_OUTM;
            idx   <= '0;
          end
        end
        PH_OUTM: begin
          if (idx == AW'(N_OUT - 1)) begin
            phase <= PH_REV;
            idx   <= AW'(N_NODES - 1);
          end else idx <= idx + 1'b1;
        end
        PH_REV: begin
          if (idx == '0) phase <= PH_FWD;
          else idx <= idx - 1'b1;
        end
        PH_FWD: begin
          if (idx == AW'(N_NODES - 1)) begin
            phase <= PH_OUTD;
            idx   <= '0;
          end else idx <= idx + 1'b1;
        end
        PH_OUTD: begin
          if (idx == AW'(N_OUT - 1)) phase <= PH_DONE;
          else idx <= idx + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_accept_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_OUTM && idx == '0 && !done));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REV) |=> (phase == PH_REV || phase == PH_FWD));

endmodule

// File: rtl/gcost_mark.sv
module gcost_mark
  import gcost_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int SW   = 5,
  parameter int AW   = 5,
  localparam int NS  = 2 ** SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  gcost_phase_e  phase,
  input  logic [AW-1:0] idx,
  input  logic [2:0]    fn,
  input  logic [SW-1:0] src_a,
  input  logic [SW-1:0] src_b,
  output logic [NS-1:0] act
);

  logic [SW-1:0] self_src;
  always_comb self_src = SW'(N_IN) + SW'(idx);

  // entries below N_IN stand for primary inputs; marking them is harmless
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
    end else if (clr) begin
      act <= '0;
    end else if (phase == PH_OUTM) begin
      act[src_b] <= 1'b1;
    end else if (phase == PH_REV && act[self_src]) begin
      act[src_a] <= 1'b1;
      if (!is_inv(fn)) act[src_b] <= 1'b1;
    end
  end

  p_marks_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FWD) |=> $stable(act));

  p_marks_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REV) |=> ((act & $past(act)) == $past(act)));

endmodule

// File: rtl/gcost_acc.sv
module gcost_acc
  import gcost_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_NODES = 16,
  parameter int SW      = 5,
  parameter int AW      = 5,
  localparam int NS     = 2 ** SW,
  localparam int DW     = $clog2(N_NODES + 1),
  localparam int TW     = $clog2(12 * N_NODES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  gcost_phase_e  phase,
  input  logic [AW-1:0] idx,
  input  logic [2:0]    fn,
  input  logic [SW-1:0] src_a,
  input  logic [SW-1:0] src_b,
  input  logic [NS-1:0] act,
  output logic [DW-1:0] gates,
  output logic [TW-1:0] trans,
  output logic [DW-1:0] path
);

  logic [DW-1:0] dep [NS];
  logic [SW-1:0] self_src;
  logic [DW-1:0] da, db, nd;

  always_comb begin
    self_src = SW'(N_IN) + SW'(idx);
    da = dep[src_a];
    db = is_inv(fn) ? '0 : dep[src_b];
    nd = DW'(1) + ((da > db) ? da : db);
  end

  // primary-input entries are never written and read as depth 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) dep[i] <= '0;
      gates <= '0;
      trans <= '0;
      path  <= '0;
    end else if (clr) begin
      gates <= '0;
      trans <= '0;
      path  <= '0;
    end else if (phase == PH_FWD && act[self_src]) begin
      dep[self_src] <= nd;
      gates <= gates + 1'b1;
      trans <= trans + TW'(gate_cost(fn));
    end else if (phase == PH_OUTD) begin
      if (dep[src_b] > path) path <= dep[src_b];
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && !clr) |=> ($stable(gates) && $stable(trans) && $stable(path)));

  p_path_le_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> (path <= gates));

  p_trans_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> ((int'(trans) >= 2 * int'(gates)) && (int'(trans) <= 12 * int'(gates))));

  p_gate_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> (int'(gates) <= N_NODES));

endmodule

// File: rtl/gate_graph_cost.sv
module gate_graph_cost
  import gcost_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_NODES = 16,
  parameter int N_OUT   = 4,
  localparam int SW     = $clog2(N_IN + N_NODES),
  localparam int AW     = $clog2(N_NODES + N_OUT),
  localparam int WW     = 3 + 2 * SW,
  localparam int DW     = $clog2(N_NODES + 1),
  localparam int TW     = $clog2(12 * N_NODES + 1),
  localparam int NS     = 2 ** SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] rd_addr,
  input  logic [WW-1:0] rd_data,
  output logic          done,
  output logic [DW-1:0] gate_cnt,
  output logic [TW-1:0] trans_cnt,
  output logic [DW-1:0] path_len
);

  gcost_phase_e  phase;
  logic [AW-1:0] idx;
  logic          accept;
  logic [2:0]    fn;
  logic [SW-1:0] src_a, src_b;
  logic [NS-1:0] act;

  always_comb begin
    fn    = rd_data[WW-1 -: 3];
    src_a = rd_data[2*SW-1 -: SW];
    src_b = rd_data[SW-1:0];
  end

  gcost_seq #(.N_NODES(N_NODES), .N_OUT(N_OUT), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .idx(idx),
    .rd_addr(rd_addr), .accept(accept), .done(done)
  );

  gcost_mark #(.N_IN(N_IN), .SW(SW), .AW(AW)) u_mark (
    .clk(clk), .rst_n(rst_n), .clr(accept), .phase(phase), .idx(idx),
    .fn(fn), .src_a(src_a), .src_b(src_b), .act(act)
  );

  gcost_acc #(.N_IN(N_IN), .N_NODES(N_NODES), .SW(SW), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(accept), .phase(phase), .idx(idx),
    .fn(fn), .src_a(src_a), .src_b(src_b), .act(act),
    .gates(gate_cnt), .trans(trans_cnt), .path(path_len)
  );

endmodule

// File: tb/tb_gate_graph_cost.sv
module tb_gate_graph_cost;
  localparam int NI = 4, NN = 16, NO = 4;
  localparam int SW = 5, AW = 5, WW = 13, DW = 5, TW = 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] rd_data;
  logic done;
  logic [DW-1:0] gate_cnt, path_len;
  logic [TW-1:0] trans_cnt;

  int fn_m[NN], a_m[NN], b_m[NN], o_m[NO];
  int nchk = 0, nerr = 0, cyc = 0;
  bit exp_busy = 0, exp_done = 0;
  int cnt = 0, e_gates = 0, e_trans = 0, e_path = 0;

  always #4 clk = ~clk;

  gate_graph_cost dut (.clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .gate_cnt(gate_cnt), .trans_cnt(trans_cnt),
    .path_len(path_len));

  always_comb begin
    int ia;
    ia = int'(rd_addr);
    if (ia < NN) rd_data = {3'(fn_m[ia]), 5'(a_m[ia]), 5'(b_m[ia])};
    else if (ia < NN + NO) rd_data = {8'd0, 5'(o_m[ia - NN])};
    else rd_data = '0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wcost(input int f);
    if (f <= 1) return 6;
    if (f <= 3) return 4;
    if (f <= 5) return 12;
    return 2;
  endfunction

  // fixed-point reference: reachability and depth iterated to convergence
  task automatic compute_exp();
    bit av[NN];
    int dp[NN];
    bit changed;
    foreach (av[j]) begin av[j] = 0; dp[j] = 0; end
    for (int k = 0; k < NO; k++) if (o_m[k] >= NI) av[o_m[k] - NI] = 1;
    changed = 1;
    while (changed) begin
      changed = 0;
      for (int j = 0; j < NN; j++) if (av[j]) begin
        if (a_m[j] >= NI && !av[a_m[j] - NI]) begin av[a_m[j] - NI] = 1; changed = 1; end
        if (fn_m[j] < 6 && b_m[j] >= NI && !av[b_m[j] - NI]) begin av[b_m[j] - NI] = 1; changed = 1; end
      end
    end
    e_gates = 0; e_trans = 0;
    for (int j = 0; j < NN; j++) if (av[j]) begin e_gates++; e_trans += wcost(fn_m[j]); end
    for (int r = 0; r < NN; r++)
      for (int j = 0; j < NN; j++) if (av[j]) begin
        int x, y;
        x = (a_m[j] >= NI) ? dp[a_m[j] - NI] : 0;
        y = (fn_m[j] < 6 && b_m[j] >= NI) ? dp[b_m[j] - NI] : 0;
        dp[j] = 1 + ((x > y) ? x : y);
      end
    e_path = 0;
    for (int k = 0; k < NO; k++)
      if (o_m[k] >= NI && dp[o_m[k] - NI] > e_path) e_path = dp[o_m[k] - NI];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_busy = 0; exp_done = 0;
    end else if (!exp_busy && start) begin
      exp_busy = 1; exp_done = 0; cnt = 2 * (NN + NO);
      compute_exp();
    end else if (exp_busy) begin
      cnt--;
      if (cnt == 0) begin exp_busy = 0; exp_done = 1; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(done === exp_done, "R6 done timing", int'(done), int'(exp_done));
      if (exp_done) begin
        chk(int'(gate_cnt) == e_gates, "R2 gate count", int'(gate_cnt), e_gates);
        chk(int'(trans_cnt) == e_trans, "R3 transistor total", int'(trans_cnt), e_trans);
        chk(int'(path_len) == e_path, "R4 path length", int'(path_len), e_path);
      end
    end
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic run(input bit poke_mid);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(int'(rd_addr) == NN, "R5 first output gene address", int'(rd_addr), NN);
    repeat (NO) @(negedge clk);
    chk(int'(rd_addr) == NN - 1, "R5 reverse pass start address", int'(rd_addr), NN - 1);
    if (poke_mid) begin
      start = 1;
      @(negedge clk) start = 0;
    end
    while (!exp_done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic rand_geno();
    for (int j = 0; j < NN; j++) begin
      fn_m[j] = $urandom % 8;
      a_m[j] = $urandom % (NI + j);
      b_m[j] = $urandom % (NI + j);
    end
    for (int k = 0; k < NO; k++) o_m[k] = $urandom % (NI + NN);
  endtask

  initial begin
    for (int j = 0; j < NN; j++) begin fn_m[j] = 0; a_m[j] = 0; b_m[j] = 1; end
    for (int k = 0; k < NO; k++) o_m[k] = 0;
    repeat (3) @(negedge clk);
    chk(done == 0 && gate_cnt == 0 && trans_cnt == 0 && path_len == 0, "R8 reset state",
        int'(gate_cnt) + int'(trans_cnt) + int'(path_len) + int'(done), 0);
    rst_n = 1;
    @(negedge clk);

    // outputs on primary inputs only: every node is neutral (R4, R1)
    rand_geno();
    for (int k = 0; k < NO; k++) o_m[k] = k;
    run(0);
    chk(gate_cnt == 0 && path_len == 0, "R1 all nodes neutral", int'(gate_cnt), 0);

    // full chain through every function code
    for (int j = 0; j < NN; j++) begin
      fn_m[j] = j % 8; a_m[j] = (j == 0) ? 0 : NI + j - 1; b_m[j] = 1;
    end
    for (int k = 0; k < NO; k++) o_m[k] = NI + NN - 1;
    run(0);
    chk(int'(path_len) == NN, "R4 deep chain", int'(path_len), NN);

    // node reachable only via an inverter's second source stays inactive
    for (int j = 0; j < NN; j++) begin fn_m[j] = 4; a_m[j] = 0; b_m[j] = 1; end
    fn_m[0] = 0; a_m[0] = 0; b_m[0] = 1;
    fn_m[1] = 4; a_m[1] = 2; b_m[1] = 3;
    fn_m[2] = 6; a_m[2] = NI; b_m[2] = NI + 1;
    for (int k = 0; k < NO; k++) o_m[k] = NI + 2;
    run(0);
    chk(int'(gate_cnt) == 2, "R1 inverter second source ignored", int'(gate_cnt), 2);
    chk(int'(trans_cnt) == 8, "R3 and plus inverter", int'(trans_cnt), 8);

    for (int t = 0; t < 6; t++) begin
      rand_geno();
      run(t == 2);
      if (t == 2) chk(int'(gate_cnt) == e_gates, "R7 start during run ignored", int'(gate_cnt), e_gates);
    end
    repeat (5) @(negedge clk);
    chk(done == 1, "R7 counts held after done", int'(done), 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule